// File: doc/BRIEF.md
# Requester-ID to Stream-ID Translation Table

This block converts the 16-bit requester ID carried by a PCIe transaction (bus, device, function) into the 6-bit stream ID and 3-bit access-controller index that the downstream IOMMU and interrupt-translation logic consume. It holds 32 programmable entries. Each entry stores a reference requester ID, a 16-bit compare mask, a stream ID, a controller index and a valid flag. A lookup strobe with a requester ID produces a registered result one clock later. The lowest-numbered matching entry supplies the stream ID and controller index.

Software programs the table indirectly through three registers on a simple synchronous port. Writes land on the rising edge, and reads are combinational from the address. Software first stages the entry contents in two data words. It then writes the entry index to the control register. That index write starts a small commit controller, which has three states:

- **ST_IDLE** waits for an accepted control write. A control write with the access-select bit clear takes the transition *store-request* to ST_STORE. A control write with that bit set takes the transition *load-request* to ST_LOAD.
- **ST_STORE** copies the staged words into the selected entry, then takes *store-done* back to ST_IDLE.
- **ST_LOAD** copies the selected entry back into the staging words, then takes *load-done* back to ST_IDLE.

Top module: `rid_sid_lut`

## Requirements
- R1: After reset both staging words and the control register read as zero, and every lookup misses.
- R2: Data word 1 (address 1) holds the valid flag at bit 31, the controller index at bits 10:8 and the stream ID at bits 5:0. Its other bits read back as zero, so only stream IDs 0 to 63 can be stored.
- R3: Data word 2 (address 2) holds the reference requester ID at bits 31:16 and the compare mask at bits 15:0. It reads back exactly as written.
- R4: Writes to the data words never alter the table until an index write commits them.
- R5: A control write (address 0) with bit 16 clear stores the staged words into the entry named by bits 4:0. A lookup issued two cycles after that write sees the new entry.
- R6: A control write with bit 16 set loads the named entry back into both staging words. The control register reads back the index at bits 4:0 and the select bit at bit 16.
- R7: An entry matches when its valid flag is set and ((lookup ID XOR stored ID) AND mask) is zero. A mask bit of 1 forces that bit to compare. An entry whose valid flag is clear never matches.
- R8: When several entries match, the lowest-numbered entry supplies the result.
- R9: On a miss the hit flag is low and both the stream ID and the controller index are zero.
- R10: The result and its valid pulse appear exactly one clock after the lookup strobe. With no strobe, the result-valid output stays low.
- R11: A control write that arrives while the controller is in ST_STORE or ST_LOAD is ignored. The controller spends exactly one cycle in either of those states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 data word 1, 2 data word 2 |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| lk_valid | input | 1 | Lookup request strobe |
| lk_rid | input | 16 | Requester ID to translate |
| res_valid | output | 1 | Lookup result valid, one cycle after lk_valid |
| res_hit | output | 1 | Some entry matched |
| res_sid | output | 6 | Stream ID of the winning entry |
| res_acx | output | 3 | Access-controller index of the winning entry |

## Verification
The situation hardest to reach from the ports is a second index write that arrives while the controller is still committing the first one. Proving the second write was dropped needs evidence from the table itself. The stimulus issues two control writes on consecutive cycles with fresh staged contents. It then looks up the staged ID to confirm the first entry landed. Finally it reads the second entry back through the load path, where it must still show a clear valid flag. Priority is driven by overlapping a masked bus-wide entry with an exact entry at a higher index.

// File: rtl/rsl_pkg.sv
package rsl_pkg;
    localparam int RID_W = 16;
    localparam int SID_W = 6;
    localparam int ACX_W = 3;

    localparam logic [1:0] A_CTL = 2'd0;
    localparam logic [1:0] A_W1  = 2'd1;
    localparam logic [1:0] A_W2  = 2'd2;

    localparam int W1_VLD    = 31;
    localparam int W1_ACX_LO = 8;
    localparam int W2_RID_LO = 16;
    localparam int CTL_RWA   = 16;

    typedef struct packed {
        logic             vld;
        logic [ACX_W-1:0] acx;
        logic [SID_W-1:0] sid;
        logic [RID_W-1:0] rid;
        logic [RID_W-1:0] msk;
    } ent_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_STORE = 2'd1,
        ST_LOAD  = 2'd2
    } cst_t;
endpackage

// File: rtl/rsl_regs.sv
module rsl_regs
    import rsl_pkg::*;
#(
    parameter int N_ENT = 32,
    parameter int IDX_W = $clog2(N_ENT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  ent_t             ld_ent,
    output logic             cm_we,
    output logic [IDX_W-1:0] cm_idx,
    output ent_t             stg,
    output logic             busy
);
    cst_t             state_q, state_d;
    ent_t             stg_q;
    logic [IDX_W-1:0] idx_q;
    logic             rwa_q;
    logic             ld_en;
    logic             ctl_hit;

    assign ctl_hit = reg_wr && (reg_addr == A_CTL) && (state_q == ST_IDLE);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ctl_hit)
                    state_d = reg_wdata[CTL_RWA] ? ST_LOAD : ST_STORE;
            end
            ST_STORE: state_d = ST_IDLE;
            ST_LOAD:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state outputs
    always_comb begin
        cm_we = 1'b0;
        ld_en = 1'b0;
        busy  = 1'b1;
        unique case (state_q)
            ST_IDLE:  busy  = 1'b0;
            ST_STORE: cm_we = 1'b1;
            ST_LOAD:  ld_en = 1'b1;
            default:  busy  = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            rwa_q <= 1'b0;
        end else if (ctl_hit) begin
            idx_q <= reg_wdata[IDX_W-1:0];
            rwa_q <= reg_wdata[CTL_RWA];
        end
    end

    // staging words; a load-back takes precedence over a data write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_q <= '0;
        end else if (ld_en) begin
            stg_q <= ld_ent;
        end else if (reg_wr) begin
            if (reg_addr == A_W1) begin
                stg_q.vld <= reg_wdata[W1_VLD];
                stg_q.acx <= reg_wdata[W1_ACX_LO +: ACX_W];
                stg_q.sid <= reg_wdata[SID_W-1:0];
            end
            if (reg_addr == A_W2) begin
                stg_q.rid <= reg_wdata[W2_RID_LO +: RID_W];
                stg_q.msk <= reg_wdata[RID_W-1:0];
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_CTL: begin
                reg_rdata[IDX_W-1:0] = idx_q;
                reg_rdata[CTL_RWA]   = rwa_q;
            end
            A_W1: begin
                reg_rdata[W1_VLD]              = stg_q.vld;
                reg_rdata[W1_ACX_LO +: ACX_W]  = stg_q.acx;
                reg_rdata[SID_W-1:0]           = stg_q.sid;
            end
            A_W2: begin
                reg_rdata[W2_RID_LO +: RID_W]  = stg_q.rid;
                reg_rdata[RID_W-1:0]           = stg_q.msk;
            end
            default: reg_rdata = '0;
        endcase
    end

    assign cm_idx = idx_q;
    assign stg    = stg_q;
endmodule

// File: rtl/rsl_table.sv
module rsl_table
    import rsl_pkg::*;
#(
    parameter int N_ENT = 32,
    parameter int IDX_W = $clog2(N_ENT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  ent_t             wdata,
    input  logic [IDX_W-1:0] ridx,
    output ent_t             rdata,
    output ent_t [N_ENT-1:0] tbl_o
);
    ent_t [N_ENT-1:0] tbl_q;

    for (genvar g = 0; g < N_ENT; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n)
                tbl_q[g] <= '0;
            else if (we && (widx == IDX_W'(g)))
                tbl_q[g] <= wdata;
        end
    end

    assign rdata = tbl_q[ridx];
    assign tbl_o = tbl_q;
endmodule

// File: rtl/rsl_match.sv
module rsl_match
    import rsl_pkg::*;
#(
    parameter int N_ENT = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [RID_W-1:0] lk_rid,
    input  ent_t [N_ENT-1:0] tbl,
    output logic             res_valid,
    output logic             res_hit,
    output logic [SID_W-1:0] res_sid,
    output logic [ACX_W-1:0] res_acx
);
    logic [N_ENT-1:0] hv;
    logic             w_hit;
    logic [SID_W-1:0] w_sid;
    logic [ACX_W-1:0] w_acx;

    for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
        assign hv[g] = tbl[g].vld && (((lk_rid ^ tbl[g].rid) & tbl[g].msk) == '0);
    end

    // walk downward so the lowest matching index is assigned last
    always_comb begin
        w_hit = 1'b0;
        w_sid = '0;
        w_acx = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (hv[i]) begin
                w_hit = 1'b1;
                w_sid = tbl[i].sid;
                w_acx = tbl[i].acx;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
            res_sid   <= '0;
            res_acx   <= '0;
        end else begin
            res_valid <= lk_valid;
            res_hit   <= lk_valid && w_hit;
            res_sid   <= lk_valid ? w_sid : '0;
            res_acx   <= lk_valid ? w_acx : '0;
        end
    end
endmodule

// File: rtl/rid_sid_lut.sv
module rid_sid_lut
    import rsl_pkg::*;
#(
    parameter int N_ENT = 32,
    parameter int IDX_W = $clog2(N_ENT)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        lk_valid,
    input  logic [15:0] lk_rid,
    output logic        res_valid,
    output logic        res_hit,
    output logic [5:0]  res_sid,
    output logic [2:0]  res_acx
);
    logic             cm_we;
    logic [IDX_W-1:0] cm_idx;
    ent_t             stg;
    ent_t             ld_ent;
    logic             busy;
    ent_t [N_ENT-1:0] tbl_w;

    rsl_regs #(.N_ENT(N_ENT), .IDX_W(IDX_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ld_ent    (ld_ent),
        .cm_we     (cm_we),
        .cm_idx    (cm_idx),
        .stg       (stg),
        .busy      (busy)
    );

    rsl_table #(.N_ENT(N_ENT), .IDX_W(IDX_W)) u_table (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cm_we),
        .widx  (cm_idx),
        .wdata (stg),
        .ridx  (cm_idx),
        .rdata (ld_ent),
        .tbl_o (tbl_w)
    );

    rsl_match #(.N_ENT(N_ENT)) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_valid  (lk_valid),
        .lk_rid    (lk_rid),
        .tbl       (tbl_w),
        .res_valid (res_valid),
        .res_hit   (res_hit),
        .res_sid   (res_sid),
        .res_acx   (res_acx)
    );
endmodule

// File: rtl/rsl_chk.sv
module rsl_chk
    import rsl_pkg::*;
#(
    parameter int N_ENT = 32,
    parameter int IDX_W = $clog2(N_ENT)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lk_valid,
    input logic             res_valid,
    input logic             res_hit,
    input logic [5:0]       res_sid,
    input logic [2:0]       res_acx,
    input logic             cm_we,
    input logic [IDX_W-1:0] cm_idx,
    input ent_t             stg,
    input ent_t [N_ENT-1:0] tbl,
    input logic             busy
);
    // R10: result follows the strobe by one clock
    a_r10_res_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> res_valid);
    a_r10_no_res_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !res_valid);
    a_r10_hit_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        res_hit |-> res_valid);
    // R9: a miss carries zero fields
    a_r9_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !res_hit |-> (res_sid == '0 && res_acx == '0));
    // R4: table only changes on a commit
    a_r4_tbl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cm_we |=> tbl == $past(tbl));
    // R5: a commit lands the staged words in the indexed entry
    a_r5_commit_lands: assert property (@(posedge clk) disable iff (!rst_n)
        cm_we |=> tbl[$past(cm_idx)] == $past(stg));
    // R11: store/load last a single cycle
    a_r11_busy_single: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);
endmodule

bind rid_sid_lut rsl_chk #(.N_ENT(N_ENT), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_valid  (lk_valid),
    .res_valid (res_valid),
    .res_hit   (res_hit),
    .res_sid   (res_sid),
    .res_acx   (res_acx),
    .cm_we     (cm_we),
    .cm_idx    (cm_idx),
    .stg       (stg),
    .tbl       (tbl_w),
    .busy      (busy)
);

// File: tb/tb_rid_sid_lut.sv
`timescale 1ns/1ps
module tb_rid_sid_lut;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        lk_valid = 1'b0;
    logic [15:0] lk_rid = '0;
    logic        res_valid, res_hit;
    logic [5:0]  res_sid;
    logic [2:0]  res_acx;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    rid_sid_lut dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_valid(lk_valid),
        .lk_rid(lk_rid), .res_valid(res_valid), .res_hit(res_hit),
        .res_sid(res_sid), .res_acx(res_acx)
    );

    // {rid[15:0], hit, sid[5:0], acx[2:0]}
    localparam logic [25:0] VEC [10] = '{
        {16'h0100, 1'b1, 6'd5,  3'd2},   // R7 masked bus match
        {16'h01FF, 1'b1, 6'd5,  3'd2},   // R7
        {16'h0108, 1'b1, 6'd5,  3'd2},   // R8 entry 0 beats entry 1
        {16'h0200, 1'b1, 6'd33, 3'd3},   // R7
        {16'h0207, 1'b1, 6'd33, 3'd3},   // R7
        {16'h0208, 1'b0, 6'd0,  3'd0},   // R9
        {16'h0300, 1'b0, 6'd0,  3'd0},   // R7 invalid entry
        {16'hABCD, 1'b1, 6'd63, 3'd7},   // R7 exact
        {16'hABCC, 1'b0, 6'd0,  3'd0},   // R9
        {16'h0000, 1'b0, 6'd0,  3'd0}    // R9
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic look(input logic [15:0] rid, output logic v, output logic h,
                        output logic [5:0] s, output logic [2:0] x);
        @(negedge clk);
        lk_valid = 1'b1; lk_rid = rid;
        @(negedge clk);
        lk_valid = 1'b0;
        v = res_valid; h = res_hit; s = res_sid; x = res_acx;
        @(negedge clk);
        chk("R10 valid drops", {31'd0, res_valid}, 32'd0);
    endtask

    task automatic prog(input logic [4:0] idx, input logic [31:0] w1, input logic [31:0] w2);
        wr(2'd1, w1);
        wr(2'd2, w2);
        wr(2'd0, {27'd0, idx});
    endtask

    initial begin
        #500000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic v, h;
        logic [5:0] s;
        logic [2:0] x;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(2'd0, d); chk("R1 ctl", d, 32'h0);
        rd(2'd1, d); chk("R1 w1", d, 32'h0);
        rd(2'd2, d); chk("R1 w2", d, 32'h0);
        look(16'h0000, v, h, s, x);
        chk("R1 miss", {v, h, s, x}, {1'b1, 1'b0, 6'd0, 3'd0});

        // R2 / R3 field layout
        wr(2'd1, 32'hFFFF_FFFF); rd(2'd1, d); chk("R2 w1 fields", d, 32'h8000_073F);
        wr(2'd2, 32'h1234_ABCD); rd(2'd2, d); chk("R3 w2 fields", d, 32'h1234_ABCD);

        // table contents
        prog(5'd0,  32'h8000_0205, 32'h0100_FF00);
        prog(5'd1,  32'h8000_0109, 32'h0108_FFFF);
        prog(5'd3,  32'h8000_0321, 32'h0200_FFF8);
        prog(5'd5,  32'h0000_000C, 32'h0300_FFFF);
        prog(5'd31, 32'h8000_073F, 32'hABCD_FFFF);

        for (int i = 0; i < 10; i++) begin
            look(VEC[i][25:10], v, h, s, x);
            chk($sformatf("R7/R8/R9 vec%0d", i), {22'd0, v, h, s, x},
                {22'd0, 1'b1, VEC[i][9:0]});
        end

        // R4: staging alone leaves the table unchanged
        wr(2'd1, 32'h8000_010A);
        wr(2'd2, 32'h0500_FFFF);
        look(16'h0500, v, h, s, x);
        chk("R4 no commit", {v, h, s, x}, {1'b1, 1'b0, 6'd0, 3'd0});
        // R5: index write commits
        wr(2'd0, 32'd10);
        look(16'h0500, v, h, s, x);
        chk("R5 commit", {v, h, s, x}, {1'b1, 1'b1, 6'd10, 3'd1});

        // R6: load back entry 3
        wr(2'd0, 32'h0001_0003);
        rd(2'd1, d); chk("R6 load w1", d, 32'h8000_0321);
        rd(2'd2, d); chk("R6 load w2", d, 32'h0200_FFF8);
        rd(2'd0, d); chk("R6 ctl readback", d, 32'h0001_0003);

        // R11: back-to-back index writes, the second is dropped
        wr(2'd1, 32'h8000_0411);
        wr(2'd2, 32'h0600_FFFF);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 32'd20;
        @(negedge clk);
        reg_wdata = 32'd21;
        @(negedge clk);
        reg_wr = 1'b0;
        @(negedge clk);
        rd(2'd0, d); chk("R11 ctl kept", d, 32'd20);
        look(16'h0600, v, h, s, x);
        chk("R11 first landed", {v, h, s, x}, {1'b1, 1'b1, 6'd17, 3'd4});
        wr(2'd0, 32'h0001_0015);
        rd(2'd1, d); chk("R11 entry21 empty", d, 32'h0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule